// File: doc/BRIEF.md
# Differential Clock Output Gating Controller

This block turns one internal reference clock into eight differential clock outputs. Each output has a true leg and a complement leg, and each leg has its own drive-enable flag that stands in for a tri-state driver. The block gates every output pair from four sources: a per-output enable pin, a per-output enable bit from configuration, a global stop pin and a global power-down pin. It never cuts a clock pulse short, so no runt pulse appears when an output stops or starts.

The asynchronous pins pass through two-flop synchronizers in the reference clock domain. The stop and power-down requests are then qualified on the rising edges of the complement output clock. Every state change of an output is applied at the instant its true leg would rise. Configuration inputs choose which outputs a stop may halt, how stopped and powered-down outputs park (driven high or fully undriven), and whether the output runs at the full or half rate. A polarity select, captured during reset, flips the active sense of the enable, stop and power-down pins.

Top module: `dif_gate_ctrl`

## Requirements
- R1: While reset is held low, every leg of every output is undriven and low. The polarity select is captured only while reset is low.
- R2: A running output drives both legs, with the complement equal to the inverse of the true leg. All running outputs are in phase.
- R3: With cfg_full_rate at 1 the output period is 2 reference cycles. With it at 0 the period is 4 reference cycles.
- R4: A stop request is recognised, asserted or released, only after the synchronized level is the same on two consecutive complement rising edges. A stop pulse of one reference cycle has no effect on the outputs.
- R5: A recognised stop halts only the outputs whose cfg_stoppable bit is 1. The other outputs keep toggling.
- R6: A stopped output with cfg_stop_hiz at 0 drives its true leg high and leaves its complement leg undriven and low. With cfg_stop_hiz at 1, both legs are undriven and low.
- R7: After the stop is released, all stopped outputs resume on the same cycle, 2 to 6 output periods after the pin change. A parked-high true leg goes low for the first time no earlier than 4 and no later than 14 reference cycles after the release.
- R8: A power-down seen active on two consecutive complement rising edges parks every output, whatever its enable or stoppable state, at the next complement falling edge. With cfg_pd_hiz at 0 the true leg is driven high and the complement leg is undriven. With cfg_pd_hiz at 1 both legs are undriven.
- R9: An output runs only when both its pin enable and its cfg_out_en bit are active. A disabled output leaves both legs undriven and low. A pin change takes effect within 2 to 7 reference cycles at full rate.
- R10: With the captured polarity at 0, the enable pins are active high and the stop and power-down pins are active low. With the captured polarity at 1, all of these senses are inverted. Changing pol_sel after reset has no effect.
- R11: A leg whose drive-enable is 0 always reads low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pol_sel | input | 1 | Pin polarity select, captured during reset |
| oe_pin | input | N | Per-output enable pins, sense set by polarity |
| stop_pin | input | 1 | Global stop pin, asynchronous |
| pd_pin | input | 1 | Global power-down pin, asynchronous |
| cfg_full_rate | input | 1 | 1 = full output rate, 0 = half rate |
| cfg_out_en | input | N | Per-output enable bits from configuration |
| cfg_stoppable | input | N | 1 = output may be halted by stop |
| cfg_stop_hiz | input | 1 | Stop parking: 0 = true driven high, 1 = both legs undriven |
| cfg_pd_hiz | input | 1 | Power-down parking: 0 = true driven high, 1 = both legs undriven |
| dif_t | output | N | True leg values |
| dif_c | output | N | Complement leg values |
| dif_t_drv | output | N | True leg drive-enables |
| dif_c_drv | output | N | Complement leg drive-enables |

## Verification
The assertions check four properties on every cycle: the complement is the inverse of the true leg wherever both legs drive, undriven legs read low, a complement never drives without its true leg, and all running outputs are in phase. They also check that the qualified stop state moves only on complement rising edges, and that a qualified power-down releases every complement driver. The directed scenarios cover the rest, which needs counting over many cycles. That includes the output period in each rate, the filtering of short stop pulses, the restart window and its simultaneity, the enable latency, and the inverted pin sense under the opposite polarity.

// File: rtl/dif_gate_pkg.sv
package dif_gate_pkg;

    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_RUN  = 2'd1,
        LEG_STOP = 2'd2,
        LEG_PD   = 2'd3
    } leg_mode_e;

endpackage

// File: rtl/dif_gate_sync.sv
module dif_gate_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign d_out = st_q.s2;
endmodule

// File: rtl/dif_gate_qual.sv
module dif_gate_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    input  logic level,
    output logic valid
);
    typedef struct packed {
        logic smp;
        logic vld;
    } qual_st_t;

    qual_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (smp_en) begin
            st_d.smp = level;
            if (level == st_q.smp) st_d.vld = level;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.vld;
endmodule

// File: rtl/dif_gate_lane.sv
module dif_gate_lane
    import dif_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic park_evt,
    input  logic pd_req,
    input  logic enable,
    input  logic stop_req,
    input  logic ph,
    input  logic stop_hiz,
    input  logic pd_hiz,
    output logic t,
    output logic c,
    output logic t_drv,
    output logic c_drv
);
    leg_mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (park_evt) begin
            if (pd_req)        mode_d = LEG_PD;
            else if (!enable)  mode_d = LEG_OFF;
            else if (stop_req) mode_d = LEG_STOP;
            else               mode_d = LEG_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= LEG_OFF;
        else        mode_q <= mode_d;
    end

    always_comb begin
        t = 1'b0; c = 1'b0; t_drv = 1'b0; c_drv = 1'b0;
        unique case (mode_q)
            LEG_RUN: begin
                t = ph; c = ~ph; t_drv = 1'b1; c_drv = 1'b1;
            end
            LEG_STOP: begin
                t = ~stop_hiz; t_drv = ~stop_hiz;
            end
            LEG_PD: begin
                t = ~pd_hiz; t_drv = ~pd_hiz;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dif_gate_ctrl.sv
module dif_gate_ctrl #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pol_sel,
    input  logic [N-1:0] oe_pin,
    input  logic         stop_pin,
    input  logic         pd_pin,
    input  logic         cfg_full_rate,
    input  logic [N-1:0] cfg_out_en,
    input  logic [N-1:0] cfg_stoppable,
    input  logic         cfg_stop_hiz,
    input  logic         cfg_pd_hiz,
    output logic [N-1:0] dif_t,
    output logic [N-1:0] dif_c,
    output logic [N-1:0] dif_t_drv,
    output logic [N-1:0] dif_c_drv
);
    localparam int CW = N + 2;

    typedef struct packed {
        logic pol;
        logic div;
        logic ph;
    } core_st_t;

    core_st_t st_d, st_q;

    logic          tog, crise_evt, park_evt;
    logic [CW-1:0] act_raw, act_s;
    logic          pd_valid, stop_valid;

    // Pins converted to active-high with the captured polarity, then synchronized.
    assign act_raw = {pd_pin ^ ~st_q.pol, stop_pin ^ ~st_q.pol, oe_pin ^ {N{st_q.pol}}};

    dif_gate_sync #(.W(CW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (act_raw),
        .d_out (act_s)
    );

    assign tog       = cfg_full_rate | st_q.div;
    assign crise_evt = tog & st_q.ph;
    assign park_evt  = tog & ~st_q.ph;

    always_comb begin
        st_d     = st_q;
        st_d.div = ~st_q.div;
        if (tog) st_d.ph = ~st_q.ph;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{pol: pol_sel, div: 1'b0, ph: 1'b0};
        else        st_q <= st_d;
    end

    dif_gate_qual u_pd_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_en (crise_evt),
        .level  (act_s[N+1]),
        .valid  (pd_valid)
    );

    dif_gate_qual u_stop_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_en (crise_evt),
        .level  (act_s[N]),
        .valid  (stop_valid)
    );

    for (genvar i = 0; i < N; i++) begin : g_lane
        dif_gate_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .park_evt (park_evt),
            .pd_req   (pd_valid),
            .enable   (act_s[i] & cfg_out_en[i]),
            .stop_req (stop_valid & cfg_stoppable[i]),
            .ph       (st_q.ph),
            .stop_hiz (cfg_stop_hiz),
            .pd_hiz   (cfg_pd_hiz),
            .t        (dif_t[i]),
            .c        (dif_c[i]),
            .t_drv    (dif_t_drv[i]),
            .c_drv    (dif_c_drv[i])
        );
    end
endmodule

// File: rtl/dif_gate_ctrl_chk.sv
module dif_gate_ctrl_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         crise_evt,
    input logic         park_evt,
    input logic         pd_valid,
    input logic         stop_valid,
    input logic [N-1:0] dif_t,
    input logic [N-1:0] dif_c,
    input logic [N-1:0] dif_t_drv,
    input logic [N-1:0] dif_c_drv
);
    logic [N-1:0] both_drv;
    assign both_drv = dif_t_drv & dif_c_drv;

    // R2: complement opposes true wherever both legs drive
    a_r2_complement: assert property (@(posedge clk) disable iff (!rst_n)
        ((dif_t ^ dif_c) | ~both_drv) == {N{1'b1}});

    // R2: all running outputs share one phase
    a_r2_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
        ((both_drv & dif_t) == '0) || ((both_drv & ~dif_t) == '0));

    // R11: undriven legs read low
    a_r11_undriven_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((dif_t & ~dif_t_drv) | (dif_c & ~dif_c_drv)) == '0);

    // R6: a complement leg never drives while its true leg is undriven
    a_r6_comp_needs_true: assert property (@(posedge clk) disable iff (!rst_n)
        (dif_c_drv & ~dif_t_drv) == '0);

    // R4: qualified stop moves only on complement rising edges
    a_r4_stop_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !crise_evt |=> $stable(stop_valid));

    // R8: qualified power-down releases every complement driver at the park edge
    a_r8_pd_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_valid && park_evt) |=> (dif_c_drv == '0));
endmodule

bind dif_gate_ctrl dif_gate_ctrl_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .crise_evt  (crise_evt),
    .park_evt   (park_evt),
    .pd_valid   (pd_valid),
    .stop_valid (stop_valid),
    .dif_t      (dif_t),
    .dif_c      (dif_c),
    .dif_t_drv  (dif_t_drv),
    .dif_c_drv  (dif_c_drv)
);

// File: tb/dif_gate_ctrl_test.sv
`timescale 1ns/1ps
module dif_gate_ctrl_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n, pol_sel, stop_pin, pd_pin;
    logic [N-1:0] oe_pin, cfg_out_en, cfg_stoppable;
    logic         cfg_full_rate, cfg_stop_hiz, cfg_pd_hiz;
    logic [N-1:0] dif_t, dif_c, dif_t_drv, dif_c_drv;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dif_gate_ctrl #(.N(N)) uut (
        .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel), .oe_pin(oe_pin),
        .stop_pin(stop_pin), .pd_pin(pd_pin), .cfg_full_rate(cfg_full_rate),
        .cfg_out_en(cfg_out_en), .cfg_stoppable(cfg_stoppable),
        .cfg_stop_hiz(cfg_stop_hiz), .cfg_pd_hiz(cfg_pd_hiz),
        .dif_t(dif_t), .dif_c(dif_c), .dif_t_drv(dif_t_drv), .dif_c_drv(dif_c_drv)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic count_rise(input int idx, input int n, output int cnt);
        logic prev;
        cnt  = 0;
        prev = dif_t[idx];
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (dif_t[idx] && !prev) cnt++;
            prev = dif_t[idx];
        end
    endtask

    task automatic do_reset(input logic pol);
        @(negedge clk);
        rst_n = 1'b0; pol_sel = pol;
        oe_pin = pol ? '0 : '1; stop_pin = ~pol; pd_pin = ~pol;
        cfg_full_rate = 1'b1; cfg_out_en = '1; cfg_stoppable = '1;
        cfg_stop_hiz = 1'b0; cfg_pd_hiz = 1'b0;
        cyc(4);
        chk("R1 reset true legs", int'(dif_t | dif_c), 0);
        chk("R1 reset drives", int'(dif_t_drv | dif_c_drv), 0);
        rst_n = 1'b1;
        cyc(20);
    endtask

    task automatic t_run;
        chk("R2 both legs driven", int'(dif_t_drv & dif_c_drv), 8'hFF);
        chk("R2 complement", int'(dif_c), int'(~dif_t & 8'hFF));
        chk("R2 in phase", int'((dif_t == '0) || (dif_t == '1)), 1);
    endtask

    task automatic t_rate;
        int cnt;
        count_rise(0, 40, cnt);
        chk_rng("R3 full rate edges", cnt, 19, 21);
        cfg_full_rate = 1'b0;
        cyc(8);
        count_rise(0, 40, cnt);
        chk_rng("R3 half rate edges", cnt, 9, 11);
        cfg_full_rate = 1'b1;
        cyc(8);
    endtask

    task automatic t_stop_filter;
        int cnt;
        stop_pin = 1'b0;
        @(negedge clk);
        stop_pin = 1'b1;
        count_rise(0, 24, cnt);
        chk_rng("R4 one-cycle stop pulse ignored", cnt, 11, 13);
    endtask

    task automatic t_stop_park;
        int cnt;
        cfg_stoppable = 8'h0F;
        stop_pin = 1'b0;
        cyc(20);
        chk("R6 parked true high", int'(dif_t[3:0]), 4'hF);
        chk("R6 parked drives", int'({dif_t_drv[3:0], dif_c_drv[3:0]}), 8'hF0);
        chk("R6 parked complement low", int'(dif_c[3:0]), 0);
        count_rise(0, 20, cnt);
        chk("R5 stoppable output halted", cnt, 0);
        count_rise(5, 20, cnt);
        chk_rng("R5 free-running output toggles", cnt, 9, 11);
    endtask

    task automatic t_restart;
        int lat;
        bit same;
        lat  = -1;
        same = 1'b1;
        stop_pin = 1'b1;
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            if (dif_t[3:0] != 4'h0 && dif_t[3:0] != 4'hF) same = 1'b0;
            if (lat < 0 && !dif_t[0]) lat = k;
        end
        chk_rng("R7 restart latency", lat, 4, 14);
        chk("R7 stopped outputs resume together", int'(same), 1);
        chk("R7 all outputs in phase after restart", int'((dif_t == '0) || (dif_t == '1)), 1);
    endtask

    task automatic t_stop_hiz;
        cfg_stop_hiz = 1'b1;
        stop_pin = 1'b0;
        cyc(20);
        chk("R6 hiz stop legs low", int'({dif_t[3:0], dif_c[3:0]}), 0);
        chk("R6 hiz stop undriven", int'({dif_t_drv[3:0], dif_c_drv[3:0]}), 0);
        stop_pin = 1'b1;
        cyc(20);
        chk("R6 hiz stop released drives", int'(dif_t_drv & dif_c_drv), 8'hFF);
        cfg_stop_hiz = 1'b0;
        cfg_stoppable = '1;
    endtask

    task automatic t_pd;
        pd_pin = 1'b0;
        cyc(20);
        chk("R8 pd true high", int'(dif_t), 8'hFF);
        chk("R8 pd true driven", int'(dif_t_drv), 8'hFF);
        chk("R8 pd complement undriven", int'(dif_c_drv | dif_c), 0);
        cfg_pd_hiz = 1'b1;
        cyc(2);
        chk("R8 pd hiz undriven", int'(dif_t_drv | dif_c_drv), 0);
        chk("R11 undriven legs low", int'(dif_t | dif_c), 0);
        pd_pin = 1'b1;
        cfg_pd_hiz = 1'b0;
        cyc(20);
        chk("R8 pd released running", int'(dif_t_drv & dif_c_drv), 8'hFF);
    endtask

    task automatic t_oe;
        int lat;
        lat = -1;
        oe_pin[2] = 1'b0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (lat < 0 && !dif_t_drv[2]) lat = k;
        end
        chk_rng("R9 pin disable latency", lat, 2, 7);
        chk("R9 disabled legs", int'({dif_t[2], dif_c[2], dif_c_drv[2]}), 0);
        chk("R9 others still driven", int'(dif_t_drv & 8'hFB), 8'hFB);
        oe_pin[2] = 1'b1;
        cfg_out_en[6] = 1'b0;
        cyc(10);
        chk("R9 register disable", int'({dif_t_drv[6], dif_c_drv[6], dif_t[6]}), 0);
        cfg_out_en[6] = 1'b1;
        cyc(10);
        chk("R9 re-enabled", int'(dif_t_drv & dif_c_drv), 8'hFF);
    endtask

    task automatic t_pol;
        do_reset(1'b1);
        chk("R10 inverted sense running", int'(dif_t_drv & dif_c_drv), 8'hFF);
        pol_sel = 1'b0;
        cyc(10);
        chk("R10 pol_sel ignored after reset", int'(dif_t_drv & dif_c_drv), 8'hFF);
        oe_pin[1] = 1'b1;
        cyc(10);
        chk("R10 enable active low", int'(dif_t_drv[1]), 0);
        oe_pin[1] = 1'b0;
        stop_pin = 1'b1;
        cyc(20);
        chk("R10 stop active high", int'({dif_t, dif_c_drv}), 16'hFF00);
        stop_pin = 1'b0;
        pd_pin = 1'b1;
        cyc(20);
        chk("R10 pd active high", int'({dif_t_drv, dif_c_drv}), 16'hFF00);
        pd_pin = 1'b0;
        cyc(20);
        chk("R10 pd released", int'(dif_t_drv & dif_c_drv), 8'hFF);
    endtask

    initial begin
        cyc(100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        t_run();
        t_rate();
        t_stop_filter();
        t_stop_park();
        t_restart();
        t_stop_hiz();
        t_pd();
        t_oe();
        t_pol();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule